// File: doc/BRIEF.md
# Software-Break Bus Sequencer

This block plays out the memory traffic of an 8-bit processor's software-break instruction, one bus transaction per clock. On a start request it captures the program counter, stack pointer and status byte. It then steps through seven bus cycles in a fixed order. The first two are reads of the opcode and a discarded padding byte. The next three are stack pushes of the return address and a flagged status copy. The last two are reads of a fixed two-byte vector. Each access falls on its own cycle, so a device on the bus sees every read and write at the cycle where the instruction really makes it.

The ready input can hold any read cycle, and the address stays on the bus while it is held. Write cycles never wait. A marker output flags the opcode fetch so that an observer can tell it apart from ordinary reads. When the sequence completes, a one-clock done pulse presents the new program counter, the stack pointer after three pushes and the status byte with interrupts masked. A surrounding core uses these values to resume execution.

Top module: `swi_bus_seq`

## Requirements
- R1: After a synchronous reset, even one applied mid-sequence, `bus_en` and `done` are low in the next cycle and stay low until `start`.
- R2: A `start` sampled while idle gives exactly seven completed bus transactions, beginning in the next cycle. Cycle 1 reads address PC. Cycle 2 reads PC+1, modulo 2^16, and its data is discarded.
- R3: Cycle 3 writes the high byte of PC+2 to 0x0100+SP. Cycle 4 writes the low byte of PC+2 to 0x0100+(SP-1). The stack pointer wraps within 8 bits.
- R4: Cycle 5 writes the status byte to 0x0100+(SP-2), with bit 4 forced to 1 in the written copy.
- R5: Cycle 6 reads 0xFFFE and cycle 7 reads 0xFFFF. The new PC is (byte from 0xFFFF)×256 + (byte from 0xFFFE).
- R6: `sync` is high only during cycle 1, and only while that cycle is a read (`rw`=1 means read).
- R7: While `rdy` is low in a read cycle, the sequence does not advance: the same address and `rw`=1 are presented in the next cycle.
- R8: Write cycles 3 to 5 each take exactly one clock, whatever `rdy` is.
- R9: `done` is high for exactly one clock, in the cycle after cycle 7 completes. With `done`, `pc_out` holds the new PC, `sp_out` holds SP-3 (8-bit wrap) and `p_out` holds the entry status with bit 2 set. With no stalls, `done` comes 8 cycles after the `start` edge.
- R10: `start` while a sequence is running is ignored: the running sequence and its results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a break sequence (taken only while idle) |
| pc_in | input | 16 | Opcode address |
| sp_in | input | 8 | Stack pointer at entry |
| p_in | input | 8 | Status byte at entry |
| rdata | input | 8 | Read data from the bus |
| rdy | input | 1 | Ready; low holds a read cycle |
| addr | output | 16 | Bus address |
| rw | output | 1 | 1 = read, 0 = write |
| wdata | output | 8 | Write data |
| sync | output | 1 | Opcode fetch marker |
| bus_en | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| pc_out | output | 16 | New program counter |
| sp_out | output | 8 | Stack pointer after the pushes |
| p_out | output | 8 | Status with interrupt mask set |

## Verification
Cycle 1 appears on the bus in the clock after the edge that samples `start`. Each later cycle follows one clock after the previous transaction completes, which is a write or a read with `rdy` high. `done` and the result ports are due in the clock right after the 0xFFFF read completes. The bench drives `rdy` and samples every output at the falling edge. It counts only completed transactions, so a stalled read is compared against the hold rule rather than the next expected access. In stall-free runs it also checks that `done` arrives exactly eight cycles after start.

// File: rtl/swi_pkg.sv
package swi_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_OP, ST_PAD, ST_PCH, ST_PCL, ST_PSW, ST_VL, ST_VH, ST_FIN
   } step_t;

   function automatic logic step_writes(step_t s);
      return (s == ST_PCH) || (s == ST_PCL) || (s == ST_PSW);
   endfunction

   function automatic logic step_on_bus(step_t s);
      return (s != ST_IDLE) && (s != ST_FIN);
   endfunction
endpackage

// File: rtl/swi_step_fsm.sv
module swi_step_fsm
   import swi_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  start,
   input  logic  rdy,
   output step_t step,
   output logic  adv,
   output logic  launch
);
   step_t nxt;

   // a cycle completes when it is a write, or a read with ready
   assign adv    = step_on_bus(step) && (step_writes(step) || rdy);
   assign launch = (step == ST_IDLE) && start;

   always_comb begin
      nxt = step;
      unique case (step)
         ST_IDLE: if (start) nxt = ST_OP;
         ST_OP:   if (adv)   nxt = ST_PAD;
         ST_PAD:  if (adv)   nxt = ST_PCH;
         ST_PCH:             nxt = ST_PCL;
         ST_PCL:             nxt = ST_PSW;
         ST_PSW:             nxt = ST_VL;
         ST_VL:   if (adv)   nxt = ST_VH;
         ST_VH:   if (adv)   nxt = ST_FIN;
         ST_FIN:             nxt = ST_IDLE;
         default:            nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) step <= ST_IDLE;
      else     step <= nxt;
   end
endmodule

// File: rtl/swi_ctx.sv
module swi_ctx
   import swi_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int I_BIT  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              launch,
   input  step_t             step,
   input  logic              adv,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] sp_in,
   input  logic [DATA_W-1:0] p_in,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] pc_r,
   output logic [DATA_W-1:0] sp_r,
   output logic [DATA_W-1:0] p_r,
   output logic [ADDR_W-1:0] vec
);
   localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);
   localparam logic [DATA_W-1:0] I_MASK = DATA_W'(1) << I_BIT;

   logic [DATA_W-1:0] vlo, vhi;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_r <= '0;
         sp_r <= '0;
         p_r  <= '0;
         vlo  <= '0;
         vhi  <= '0;
      end else begin
         if (launch) begin
            pc_r <= pc_in;
            sp_r <= sp_in;
            p_r  <= p_in;
         end
         if (adv && step_writes(step)) sp_r <= sp_r - ONE;
         if (adv && step == ST_PSW)    p_r  <= p_r | I_MASK;
         if (adv && step == ST_VL)     vlo  <= rdata;
         if (adv && step == ST_VH)     vhi  <= rdata;
      end
   end

   assign vec = {vhi, vlo};
endmodule

// File: rtl/swi_bus_mux.sv
module swi_bus_mux
   import swi_pkg::*;
#(
   parameter int                  ADDR_W     = 16,
   parameter int                  DATA_W     = 8,
   parameter logic [ADDR_W-1:0]   STACK_BASE = 16'h0100,
   parameter logic [ADDR_W-1:0]   VEC_ADDR   = 16'hFFFE,
   parameter int                  PC_INC     = 2,
   parameter int                  B_BIT      = 4
) (
   input  step_t             step,
   input  logic [ADDR_W-1:0] pc_r,
   input  logic [DATA_W-1:0] sp_r,
   input  logic [DATA_W-1:0] p_r,
   output logic              bus_en,
   output logic              rw,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata,
   output logic              sync
);
   localparam logic [DATA_W-1:0] B_MASK = DATA_W'(1) << B_BIT;
   localparam logic [ADDR_W-1:0] INC    = ADDR_W'(PC_INC);

   logic [ADDR_W-1:0] ret_pc, stk_addr;

   assign ret_pc   = pc_r + INC;
   assign stk_addr = STACK_BASE + {{(ADDR_W-DATA_W){1'b0}}, sp_r};

   assign bus_en = step_on_bus(step);
   assign rw     = !step_writes(step);
   assign sync   = (step == ST_OP);

   always_comb begin
      addr  = '0;
      wdata = '0;
      unique case (step)
         ST_OP:  addr = pc_r;
         ST_PAD: addr = pc_r + ADDR_W'(1);
         ST_PCH: begin addr = stk_addr; wdata = ret_pc[ADDR_W-1:DATA_W]; end
         ST_PCL: begin addr = stk_addr; wdata = ret_pc[DATA_W-1:0];      end
         ST_PSW: begin addr = stk_addr; wdata = p_r | B_MASK;            end
         ST_VL:  addr = VEC_ADDR;
         ST_VH:  addr = VEC_ADDR + ADDR_W'(1);
         default: begin addr = '0; wdata = '0; end
      endcase
   end
endmodule

// File: rtl/swi_bus_seq.sv
module swi_bus_seq
   import swi_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] STACK_BASE = 16'h0100,
   parameter logic [ADDR_W-1:0] VEC_ADDR   = 16'hFFFE,
   parameter int                PC_INC     = 2,
   parameter int                B_BIT      = 4,
   parameter int                I_BIT      = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] sp_in,
   input  logic [DATA_W-1:0] p_in,
   input  logic [DATA_W-1:0] rdata,
   input  logic              rdy,
   output logic [ADDR_W-1:0] addr,
   output logic              rw,
   output logic [DATA_W-1:0] wdata,
   output logic              sync,
   output logic              bus_en,
   output logic              done,
   output logic [ADDR_W-1:0] pc_out,
   output logic [DATA_W-1:0] sp_out,
   output logic [DATA_W-1:0] p_out
);
   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("address width must be twice the data width");
      end
      if (STACK_BASE[DATA_W-1:0] != '0) begin : g_bad_stack
         $error("stack base must be page aligned");
      end
      if (B_BIT >= DATA_W || I_BIT >= DATA_W || B_BIT == I_BIT) begin : g_bad_flag
         $error("flag bit positions out of range");
      end
   endgenerate

   step_t             step;
   logic              adv, launch;
   logic [ADDR_W-1:0] pc_r;
   logic [DATA_W-1:0] sp_r, p_r;

   swi_step_fsm u_fsm (
      .clk(clk), .rst(rst), .start(start), .rdy(rdy),
      .step(step), .adv(adv), .launch(launch)
   );

   swi_ctx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .I_BIT(I_BIT)) u_ctx (
      .clk(clk), .rst(rst), .launch(launch), .step(step), .adv(adv),
      .pc_in(pc_in), .sp_in(sp_in), .p_in(p_in), .rdata(rdata),
      .pc_r(pc_r), .sp_r(sp_r), .p_r(p_r), .vec(pc_out)
   );

   swi_bus_mux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STACK_BASE(STACK_BASE),
      .VEC_ADDR(VEC_ADDR), .PC_INC(PC_INC), .B_BIT(B_BIT)
   ) u_bus (
      .step(step), .pc_r(pc_r), .sp_r(sp_r), .p_r(p_r),
      .bus_en(bus_en), .rw(rw), .addr(addr), .wdata(wdata), .sync(sync)
   );

   assign done   = (step == ST_FIN);
   assign sp_out = sp_r;
   assign p_out  = p_r;
endmodule

// File: rtl/swi_bus_seq_chk.sv
module swi_bus_seq_chk #(
   parameter int                ADDR_W     = 16,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] STACK_BASE = 16'h0100,
   parameter logic [ADDR_W-1:0] VEC_ADDR   = 16'hFFFE
) (
   input logic              clk,
   input logic              rst,
   input logic              rdy,
   input logic              bus_en,
   input logic              rw,
   input logic [ADDR_W-1:0] addr,
   input logic              sync,
   input logic              done
);
   p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!bus_en && !done));

   p_sync_read_r6: assert property (@(posedge clk) disable iff (rst)
      sync |-> (bus_en && rw));

   p_read_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (bus_en && rw && !rdy) |=> (bus_en && rw && $stable(addr)));

   p_write_moves_r8: assert property (@(posedge clk) disable iff (rst)
      (bus_en && !rw) |=> (!$stable(addr) || rw || !bus_en));

   p_stack_page_r3: assert property (@(posedge clk) disable iff (rst)
      (bus_en && !rw) |-> (addr[ADDR_W-1:DATA_W] == STACK_BASE[ADDR_W-1:DATA_W]));

   p_done_after_vec_r9: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(bus_en && rw && rdy && addr == VEC_ADDR + ADDR_W'(1)));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
endmodule

bind swi_bus_seq swi_bus_seq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STACK_BASE(STACK_BASE), .VEC_ADDR(VEC_ADDR)
) u_chk (
   .clk(clk), .rst(rst), .rdy(rdy), .bus_en(bus_en), .rw(rw),
   .addr(addr), .sync(sync), .done(done)
);

// File: tb/sim_swi_bus_seq.sv
module sim_swi_bus_seq;
   logic        clk = 1'b0;
   logic        rst, start, rdy;
   logic [15:0] pc_in, addr, pc_out;
   logic [7:0]  sp_in, p_in, rdata, wdata, sp_out, p_out;
   logic        rw, sync, bus_en, done;
   logic [15:0] pc_m;
   logic [7:0]  vl_m, vh_m;
   int          n_chk = 0, n_err = 0;
   bit          finished = 0;

   always #2 clk = ~clk;

   swi_bus_seq u0 (
      .clk(clk), .rst(rst), .start(start), .pc_in(pc_in), .sp_in(sp_in),
      .p_in(p_in), .rdata(rdata), .rdy(rdy), .addr(addr), .rw(rw),
      .wdata(wdata), .sync(sync), .bus_en(bus_en), .done(done),
      .pc_out(pc_out), .sp_out(sp_out), .p_out(p_out)
   );

   // memory model
   always_comb begin
      if (addr == 16'hFFFE)      rdata = vl_m;
      else if (addr == 16'hFFFF) rdata = vh_m;
      else if (addr == pc_m)     rdata = 8'h00;
      else                       rdata = 8'hEA;
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_addr(int k, logic [15:0] pc, logic [7:0] sp);
      case (k)
         0: return pc;
         1: return pc + 16'd1;
         2: return {8'h01, sp};
         3: return {8'h01, 8'(sp - 8'd1)};
         4: return {8'h01, 8'(sp - 8'd2)};
         5: return 16'hFFFE;
         default: return 16'hFFFF;
      endcase
   endfunction

   function automatic logic [7:0] exp_wd(int k, logic [15:0] pc, logic [7:0] p);
      logic [15:0] r = pc + 16'd2;
      case (k)
         2: return r[15:8];
         3: return r[7:0];
         default: return p | 8'h10;
      endcase
   endfunction

   function automatic string req_of(int k);
      case (k)
         0, 1: return "R2";
         2, 3: return "R3";
         4: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic run_brk(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] p,
                          input logic [7:0] vl, input logic [7:0] vh,
                          input int stall_pct, input bit wr_low, input bit poke);
      int n = 0;
      int cyc = 0;
      bit prev_st = 0;
      logic [15:0] prev_a = '0;
      pc_m = pc; vl_m = vl; vh_m = vh;
      @(negedge clk);
      pc_in = pc; sp_in = sp; p_in = p; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && cyc < 100) begin
         if (prev_st) begin
            chk("R7", "held address", 32'(addr), 32'(prev_a));
            chk("R7", "held read", 32'(rw), 32'd1);
         end
         rdy = ($urandom_range(99) >= 32'(stall_pct));
         if (bus_en && !rw && wr_low) rdy = 1'b0;  // R8: writes must not wait
         if (poke && n == 2) begin
            start = 1'b1; pc_in = pc ^ 16'h5555; sp_in = ~sp; p_in = ~p;  // R10
         end
         if (bus_en && (!rw || rdy)) begin
            if (n < 7) begin
               chk(req_of(n), "address", 32'(addr), 32'(exp_addr(n, pc, sp)));
               chk(req_of(n), "rw", 32'(rw), (n >= 2 && n <= 4) ? 32'd0 : 32'd1);
               if (n >= 2 && n <= 4)
                  chk(req_of(n), "write data", 32'(wdata), 32'(exp_wd(n, pc, p)));
               chk("R6", "sync", 32'(sync), (n == 0) ? 32'd1 : 32'd0);
            end
            n++;
         end else if (bus_en) begin
            chk("R6", "sync on stall", 32'(sync), (n == 0) ? 32'd1 : 32'd0);
         end
         prev_st = bus_en && rw && !rdy;
         prev_a  = addr;
         @(negedge clk);
         start = 1'b0;
         cyc++;
      end
      chk("R2", "completed transactions", 32'(n), 32'd7);
      chk("R9", "done", 32'(done), 32'd1);
      if (stall_pct == 0) chk("R9", "cycles to done", 32'(cyc), 32'd7);
      chk("R5", "new pc", 32'(pc_out), 32'({vh, vl}));
      chk("R9", "sp out", 32'(sp_out), 32'(8'(sp - 8'd3)));
      chk("R9", "p out", 32'(p_out), 32'(p | 8'h04));
      @(negedge clk);
      chk("R9", "done one clock", 32'(done), 32'd0);
      chk("R9", "bus idle after", 32'(bus_en), 32'd0);
      rdy = 1'b1;
   endtask

   initial begin
      void'($urandom(32'd4242));
      rst = 1'b1; start = 1'b0; rdy = 1'b1;
      pc_in = '0; sp_in = '0; p_in = '0;
      pc_m = 16'h1000; vl_m = '0; vh_m = '0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "idle bus", 32'(bus_en), 32'd0);
      chk("R1", "idle done", 32'(done), 32'd0);

      run_brk(16'h1234, 8'hFD, 8'h00, 8'h78, 8'h56, 0, 0, 0);
      run_brk(16'hFFFF, 8'h01, 8'hFF, 8'h00, 8'h80, 0, 0, 0);  // pc and sp wrap
      run_brk(16'h4000, 8'h00, 8'h21, 8'hAB, 8'hCD, 0, 1, 0);  // R8
      run_brk(16'h8001, 8'h80, 8'h42, 8'h11, 8'h22, 50, 1, 0); // R7
      run_brk(16'h2222, 8'h10, 8'h03, 8'h33, 8'h44, 0, 0, 1);  // R10

      // R1: reset mid-sequence
      @(negedge clk);
      pc_in = 16'h3000; sp_in = 8'hF0; p_in = 8'h00; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1", "bus after reset", 32'(bus_en), 32'd0);
      chk("R1", "done after reset", 32'(done), 32'd0);
      @(negedge clk);
      chk("R1", "stays idle", 32'(bus_en), 32'd0);

      for (int i = 0; i < 20; i++) begin
         logic [15:0] pc = 16'($urandom_range(16'hFFFD));
         run_brk(pc, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                 30, 1'($urandom), 0);
      end

      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!finished) begin
         finished = 1;
         n_chk++; n_err++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule